// File: doc/BRIEF.md
# Edge-Detecting GPIO Interrupt Port

An eight-pin bidirectional port that sits behind a 16-bit register interface. Every pin can be turned into an output, which drives the value stored in an output data latch. Every pin can also be read back as it stands on the pad, after a two-flop synchronizer. A per-pin detector watches the synchronized level for either a rising or a falling transition, selected per pin. When the chosen transition is seen, a sticky flag is set. This happens whether the pin is an input or an output.

Software acknowledges a flag with a two-step handshake, tracked per bit. It first reads the flag register and sees the bit as 1. It then writes a 0 to that bit. A transition that lands between the read and the write cancels the acknowledge, so the flag must be read as 1 once more before a zero write can clear it. A single interrupt request is the OR, over all pins, of flag AND enable.

Top module: `gpio_edge_irq_port`

## Requirements
- R1: The direction register sits at byte offset 0x0C. Bit value 1 makes the pin an output (pin_oe high) and 0 makes it an input. After reset, every pin is an input.
- R2: Writing the output data register at 0x0E stores its low byte, and that byte appears on pin_out. Reading 0x0E returns the stored byte, whatever level the pins have.
- R3: Reading the pin-state register at 0x10 returns the pad levels of all pins. A change on pin_in becomes visible two clock edges later. Writes to 0x10 change nothing.
- R4: In the edge-select register at 0x00, bit value 1 picks rising-edge detection and 0 picks falling-edge detection, and the register resets to 0. When the picked transition occurs on a pin, that pin's flag in the register at 0x12 is set, for input and output pins alike.
- R5: A set flag stays set when the pin level changes back, or when the edge selection changes.
- R6: Writing 1 to a flag bit has no effect. Writing 0 clears the flag only if a read of 0x12 returned it as 1 beforehand. A flag that was never read as 1 is left untouched by the write.
- R7: A selected transition that arrives between the arming read and the zero write cancels the clear. After that, the flag clears only after it has been read as 1 again and then written 0.
- R8: The interrupt enable register sits at 0x0A. irq is high while any pin has both its flag and its enable set, whichever of the two was set first. Clearing the enable bit removes that pin's request.
- R9: Bits 15:8 of every register read as zero. Offsets that hold no register read as zero.
- R10: When a selected transition and a clearing zero write reach a flag in the same clock edge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Byte offset of the register accessed |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe; arms flag clears when the flag register is read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, valid in the same cycle |
| pin_in | input | 8 | Pad levels seen at the pins |
| pin_out | output | 8 | Output data driven to the pads |
| pin_oe | output | 8 | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
Two things can reach a flag at the same clock edge: a detected transition and the zero write that software issues to clear the flag. The bench sets a flag, arms it with a read, and then moves the pin so that the synchronized transition lines up exactly with the clock edge that takes the clearing write. It expects the flag to survive and the arm to be lost. A behavioural reference model runs on every clock and checks this, together with the related case where the transition comes a few cycles before the write.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned REG_ADDR_W = 5;

  localparam logic [REG_ADDR_W-1:0] OFS_EDGE_SEL = 5'h00;
  localparam logic [REG_ADDR_W-1:0] OFS_IRQ_EN   = 5'h0A;
  localparam logic [REG_ADDR_W-1:0] OFS_DIR      = 5'h0C;
  localparam logic [REG_ADDR_W-1:0] OFS_DOUT     = 5'h0E;
  localparam logic [REG_ADDR_W-1:0] OFS_PIN      = 5'h10;
  localparam logic [REG_ADDR_W-1:0] OFS_FLAG     = 5'h12;

  typedef enum logic {EDGE_FALL = 1'b0, EDGE_RISE = 1'b1} edge_sel_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] sync_q,
  output logic [WIDTH-1:0] prev_q
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0][WIDTH-1:0] stage_q;
  logic [DEPTH-1:0][WIDTH-1:0] stage_n;

  always_comb begin
    stage_n[0] = din;
    for (int i = 1; i < DEPTH; i++) begin
      stage_n[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_n;
  end

  assign sync_q = stage_q[STAGES-1];
  assign prev_q = stage_q[STAGES];
endmodule

// File: rtl/gpio_edge_flag.sv
module gpio_edge_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_hit,
  input  logic rd_hit,
  input  logic wr_hit,
  input  logic wr_bit,
  output logic flag
);
  logic flag_q, flag_n;
  logic arm_q, arm_n;

  always_comb begin
    flag_n = flag_q;
    arm_n  = arm_q;
    if (edge_hit) begin
      flag_n = 1'b1;
      arm_n  = 1'b0;
    end else if (wr_hit && !wr_bit && arm_q && flag_q) begin
      flag_n = 1'b0;
      arm_n  = 1'b0;
    end else if (rd_hit && flag_q) begin
      arm_n  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_n;
      arm_q  <= arm_n;
    end
  end

  assign flag = flag_q;

  AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> flag_q); // R4
  AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(arm_q)); // R6
  AST_EDGE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> (flag_q && !arm_q)); // R7
  AST_STICKY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !wr_hit) |=> flag_q); // R5
endmodule

// File: rtl/gpio_edge_irq_port.sv
module gpio_edge_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [NUM_PINS-1:0]   pin_in,
  output logic [NUM_PINS-1:0]   pin_out,
  output logic [NUM_PINS-1:0]   pin_oe,
  output logic                  irq
);
  localparam int unsigned PAD_W = DATA_W - NUM_PINS;

  logic [NUM_PINS-1:0] esel_q, esel_n;
  logic [NUM_PINS-1:0] ien_q,  ien_n;
  logic [NUM_PINS-1:0] dir_q,  dir_n;
  logic [NUM_PINS-1:0] dout_q, dout_n;
  logic [NUM_PINS-1:0] pin_sync, pin_prev;
  logic [NUM_PINS-1:0] edge_hit;
  logic [NUM_PINS-1:0] flags;
  logic                wr_esel, wr_ien, wr_dir, wr_dout, wr_flag, rd_flag;

  assign wr_esel = reg_wr && (reg_addr == OFS_EDGE_SEL);
  assign wr_ien  = reg_wr && (reg_addr == OFS_IRQ_EN);
  assign wr_dir  = reg_wr && (reg_addr == OFS_DIR);
  assign wr_dout = reg_wr && (reg_addr == OFS_DOUT);
  assign wr_flag = reg_wr && (reg_addr == OFS_FLAG);
  assign rd_flag = reg_rd && (reg_addr == OFS_FLAG);

  always_comb begin
    esel_n = esel_q;
    ien_n  = ien_q;
    dir_n  = dir_q;
    dout_n = dout_q;
    if (wr_esel) esel_n = reg_wdata[NUM_PINS-1:0];
    if (wr_ien)  ien_n  = reg_wdata[NUM_PINS-1:0];
    if (wr_dir)  dir_n  = reg_wdata[NUM_PINS-1:0];
    if (wr_dout) dout_n = reg_wdata[NUM_PINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      esel_q <= '0;
      ien_q  <= '0;
      dir_q  <= '0;
      dout_q <= '0;
    end else begin
      esel_q <= esel_n;
      ien_q  <= ien_n;
      dir_q  <= dir_n;
      dout_q <= dout_n;
    end
  end

  gpio_pin_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (pin_in),
    .sync_q (pin_sync),
    .prev_q (pin_prev)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    always_comb begin
      if (edge_sel_e'(esel_q[g]) == EDGE_RISE) edge_hit[g] = pin_sync[g] & ~pin_prev[g];
      else                                     edge_hit[g] = ~pin_sync[g] & pin_prev[g];
    end

    gpio_edge_flag u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .edge_hit (edge_hit[g]),
      .rd_hit   (rd_flag),
      .wr_hit   (wr_flag),
      .wr_bit   (reg_wdata[g]),
      .flag     (flags[g])
    );
  end

  always_comb begin
    unique case (reg_addr)
      OFS_EDGE_SEL: reg_rdata = {{PAD_W{1'b0}}, esel_q};
      OFS_IRQ_EN:   reg_rdata = {{PAD_W{1'b0}}, ien_q};
      OFS_DIR:      reg_rdata = {{PAD_W{1'b0}}, dir_q};
      OFS_DOUT:     reg_rdata = {{PAD_W{1'b0}}, dout_q};
      OFS_PIN:      reg_rdata = {{PAD_W{1'b0}}, pin_sync};
      OFS_FLAG:     reg_rdata = {{PAD_W{1'b0}}, flags};
      default:      reg_rdata = '0;
    endcase
  end

  assign pin_out = dout_q;
  assign pin_oe  = dir_q;
  assign irq     = |(flags & ien_q);

  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (pin_oe == $past(reg_wdata[NUM_PINS-1:0]))); // R1
  AST_PIN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_PIN) |=> ($stable(pin_out) && $stable(pin_oe))); // R3
  AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ien && reg_wdata[NUM_PINS-1:0] == '0) |=> !irq); // R8
  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 5'h02) |-> (reg_rdata == '0)); // R9
endmodule

// File: tb/tb_gpio_edge_irq_port.sv
`timescale 1ns/1ps
module tb_gpio_edge_irq_port;
  localparam logic [4:0] A_ESEL = 5'h00, A_IEN = 5'h0A, A_DIR = 5'h0C,
                         A_DOUT = 5'h0E, A_PIN = 5'h10, A_FLAG = 5'h12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [7:0]  pin_in, pin_out, pin_oe, ext = '0;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  gpio_edge_irq_port dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // Behavioural reference model
  logic [7:0] m_esel, m_ien, m_dir, m_dout, m_s1, m_s2, m_prev, m_flag, m_arm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_esel <= 0; m_ien <= 0; m_dir <= 0; m_dout <= 0;
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_flag <= 0; m_arm <= 0;
    end else begin
      logic [7:0] pad, nf, na;
      pad = (m_dir & m_dout) | (~m_dir & ext);
      nf = m_flag; na = m_arm;
      for (int b = 0; b < 8; b++) begin
        bit seen;
        seen = m_esel[b] ? (m_s2[b] && !m_prev[b]) : (!m_s2[b] && m_prev[b]);
        if (seen) begin nf[b] = 1; na[b] = 0; end
        else if (reg_wr && reg_addr == A_FLAG && !reg_wdata[b] && m_arm[b] && m_flag[b]) begin
          nf[b] = 0; na[b] = 0;
        end else if (reg_rd && reg_addr == A_FLAG && m_flag[b]) na[b] = 1;
      end
      m_flag <= nf; m_arm <= na;
      m_prev <= m_s2; m_s2 <= m_s1; m_s1 <= pad;
      if (reg_wr) begin
        case (reg_addr)
          A_ESEL: m_esel <= reg_wdata[7:0];
          A_IEN:  m_ien  <= reg_wdata[7:0];
          A_DIR:  m_dir  <= reg_wdata[7:0];
          A_DOUT: m_dout <= reg_wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [15:0] model_read(logic [4:0] a);
    case (a)
      A_ESEL: return {8'h0, m_esel};
      A_IEN:  return {8'h0, m_ien};
      A_DIR:  return {8'h0, m_dir};
      A_DOUT: return {8'h0, m_dout};
      A_PIN:  return {8'h0, m_s2};
      A_FLAG: return {8'h0, m_flag};
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, half a period after inputs change, before the next edge
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R8 irq vs model", {15'h0, irq}, {15'h0, |(m_flag & m_ien)});
      chk("R1 pin_oe vs model", {8'h0, pin_oe}, {8'h0, m_dir});
      chk("R2 pin_out vs model", {8'h0, pin_out}, {8'h0, m_dout});
      if (reg_rd) chk("R9 R3 R5 R6 R7 read vs model", reg_rdata, model_read(reg_addr));
    end
  end

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #2 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ext(logic [7:0] v);
    @(negedge clk); ext = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    idle(3); rst_n = 1; idle(2);
    // Reset state
    chk("R1 reset oe", {8'h0, pin_oe}, 16'h0);
    chk("R8 reset irq", {15'h0, irq}, 16'h0);
    rd(A_ESEL, d); chk("R4 reset edge select", d, 16'h0);
    rd(A_FLAG, d); chk("R4 reset flags", d, 16'h0);

    // Direction and output data
    wr(A_DIR, 16'h000F); wr(A_DOUT, 16'h00A5); idle(4);
    chk("R1 oe after dir write", {8'h0, pin_oe}, 16'h000F);
    chk("R2 pin_out", {8'h0, pin_out}, 16'h00A5);
    rd(A_DOUT, d); chk("R2 dout readback is latch", d, 16'h00A5);
    rd(A_PIN, d); chk("R3 pin state", d, 16'h0005);
    rd(A_FLAG, d); chk("R4 rising on falling-select gives no flag", d, 16'h0);

    // Pin state and ignored writes
    set_ext(8'h30); idle(4);
    rd(A_PIN, d); chk("R3 pin state with inputs", d, 16'h0035);
    wr(A_PIN, 16'h0000);
    rd(A_PIN, d); chk("R3 pin write ignored", d, 16'h0035);

    // Falling edge on pin 5, then sticky
    set_ext(8'h10); idle(4);
    rd(A_FLAG, d); chk("R4 falling edge flag", d, 16'h0020);
    set_ext(8'h30); idle(4);
    wr(A_ESEL, 16'h0000);
    rd(A_FLAG, d); chk("R5 flag sticky", d, 16'h0020);

    // Write 1 ignored, armed zero write clears
    wr(A_FLAG, 16'h00FF);
    rd(A_FLAG, d); chk("R6 write one no effect", d, 16'h0020);
    wr(A_FLAG, 16'h0000);
    rd(A_FLAG, d); chk("R6 armed clear", d, 16'h0000);

    // Unread flag cannot be cleared; irq with flag first
    set_ext(8'h10); idle(4);
    wr(A_IEN, 16'h0020); idle(1);
    chk("R8 irq after enable (flag first)", {15'h0, irq}, 16'h1);
    wr(A_FLAG, 16'h0000); idle(1);
    chk("R6 unread flag not cleared", {15'h0, irq}, 16'h1);
    rd(A_FLAG, d);
    wr(A_IEN, 16'h0000); idle(1);
    chk("R8 irq removed by enable clear", {15'h0, irq}, 16'h0);
    wr(A_FLAG, 16'h00DF);
    rd(A_FLAG, d); chk("R6 clear with other bits one", d, 16'h0000);

    // Enable first, then edge
    wr(A_IEN, 16'h0020);
    set_ext(8'h30); idle(4); set_ext(8'h10); idle(4);
    chk("R8 irq with enable first", {15'h0, irq}, 16'h1);

    // Edge between read and write blocks clear
    rd(A_FLAG, d);
    set_ext(8'h30); idle(4); set_ext(8'h10); idle(4);
    wr(A_FLAG, 16'h0000);
    rd(A_FLAG, d); chk("R7 intervening edge blocks clear", d, 16'h0020);
    wr(A_FLAG, 16'h0000);
    rd(A_FLAG, d); chk("R7 clear after re-read", d, 16'h0000);

    // Same-edge collision: transition and clearing write together
    set_ext(8'h30); idle(4); set_ext(8'h10); idle(4);
    rd(A_FLAG, d);
    set_ext(8'h30); idle(4);
    @(negedge clk); ext = 8'h10;
    @(negedge clk);
    @(negedge clk); reg_wr = 1; reg_addr = A_FLAG; reg_wdata = 16'h0000;
    @(negedge clk); reg_wr = 0;
    rd(A_FLAG, d); chk("R10 edge wins over clear", d, 16'h0020);

    // Rising select on an output pin
    wr(A_ESEL, 16'hFF01);
    rd(A_ESEL, d); chk("R9 upper byte reads zero", d, 16'h0001);
    wr(A_DOUT, 16'h00A4); idle(4);
    wr(A_DOUT, 16'h00A5); idle(4);
    rd(A_FLAG, d); chk("R4 rising edge on output pin", d, 16'h0021);
    rd(5'h02, d); chk("R9 unmapped offset reads zero", d, 16'h0000);

    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule